// File: doc/BRIEF.md
# Time-Slotted Shared Memory Arbiter

This block shares one memory port between a processor and a video fetch unit. Time is cut into a repeating frame of four equal slots. Each slot lasts `CLK_DIV` system clocks, which is one 8 MHz period when the system clock runs at 32 MHz. The frame order is two processor slots followed by two video slots. With this order, a processor read that lands in the first slot can be followed by a write in the very next slot, with no trip around the frame.

The processor side is a valid/ready pair. The processor raises `cpu_valid` and must hold it, along with `cpu_rom`, until `cpu_ready` pulses. That pulse is the data acknowledge. It lasts one clock and falls in the last clock of a slot the request is allowed to use. Any slot the request misses adds a wait state, and the number of missed slots is published on `cpu_wait`.

Three inputs decide who owns each slot:
- `cfg_turbo` lets any processor access use the second processor slot.
- `cfg_hires` gives the second video slot to video.
- `blank` hands the video slots to ROM reads or to memory refresh during blanking.

During display time, video owns its slots outright.

Top module: `mem_slot_arbiter`

## Requirements
- R1: While `rst_n` is low, `slot_idx` is 0 and `cpu_ready`, `vid_gnt`, `rfsh_gnt` and `cpu_wait` are all 0.
- R2: `slot_idx` steps through 0, 1, 2, 3 and then wraps to 0. Each value is held for exactly `CLK_DIV` clocks, and the first step after reset comes `CLK_DIV` clocks after release.
- R3: Slot 0 serves any processor request. `cpu_ready` is a single-clock pulse in the last clock of the serving slot, and it is only ever high while `cpu_valid` is high.
- R4: Slot 1 serves the processor only when `cpu_rom` = 1 or `cfg_turbo` = 1. Otherwise the request waits.
- R5: In slot 2 with `blank` = 0, `vid_gnt` equals `vid_req`, and the processor is never served there.
- R6: In slot 3 with `blank` = 0, `vid_gnt` equals `vid_req` when `cfg_hires` = 1 and is 0 when `cfg_hires` = 0. The processor is never served there.
- R7: In slots 2 and 3 with `blank` = 1, a pending ROM read (`cpu_valid` = 1 and `cpu_rom` = 1) is served. Otherwise `rfsh_gnt` is high for the whole slot. `vid_gnt` stays 0.
- R8: One clock after each `cpu_ready` pulse, `cpu_wait` shows how many slot ends passed while the request was pending and not served. The value ranges from 0 to 3.
- R9: At most one of `cpu_ready`, `vid_gnt` and `rfsh_gnt` is high in any clock.
- R10: Consider a RAM access in slot 0 followed at once by a second held RAM access. In turbo mode the second access reports 0 wait slots. In normal mode it reports 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_hires | input | 1 | Second video slot goes to video |
| cfg_turbo | input | 1 | Any processor access may use slot 1 |
| blank | input | 1 | Video blanking period |
| cpu_valid | input | 1 | Processor request pending |
| cpu_rom | input | 1 | Pending request is a ROM read |
| cpu_ready | output | 1 | Data acknowledge, one clock |
| cpu_wait | output | WAIT_W | Wait slots of the last served request |
| vid_req | input | 1 | Video fetch wanted |
| vid_gnt | output | 1 | Current slot granted to video |
| rfsh_gnt | output | 1 | Current slot granted to refresh |
| slot_idx | output | 2 | Current slot number |

## Verification
A wrong slot counter or divider shows up within one frame as a slot held for the wrong number of clocks, or as a skipped index on `slot_idx`. A wrong ownership decode appears in the very slot concerned: `vid_gnt` or `rfsh_gnt` has the wrong level, or `cpu_ready` lands in a slot other than the first eligible one. A wrong wait counter is caught one clock after the acknowledge, when `cpu_wait` differs from the count of slots that passed. The sweep covers every start slot under every combination of mode, blanking, ROM flag and video request.

// File: rtl/msa_pkg.sv
package msa_pkg;
  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);

  typedef enum logic [SLOT_W-1:0] {
    SLOT_CPU_A = 2'd0,
    SLOT_CPU_B = 2'd1,
    SLOT_VID_A = 2'd2,
    SLOT_VID_B = 2'd3
  } slot_e;
endpackage

// File: rtl/msa_slot_timer.sv
module msa_slot_timer
  import msa_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  output slot_e slot,
  output logic  slot_last
);
  localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] slot_nxt;

  assign slot_last = (div_q == DIV_END);
  assign slot_nxt  = slot + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      slot  <= SLOT_CPU_A;
    end else if (slot_last) begin
      div_q <= '0;
      slot  <= slot_e'(slot_nxt);
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/msa_slot_decode.sv
module msa_slot_decode
  import msa_pkg::*;
(
  input  slot_e slot,
  input  logic  cfg_hires,
  input  logic  cfg_turbo,
  input  logic  blank,
  input  logic  cpu_valid,
  input  logic  cpu_rom,
  input  logic  vid_req,
  output logic  cpu_gnt,
  output logic  vid_gnt,
  output logic  rfsh_gnt
);
  logic rom_take;
  logic vid_owned;

  assign rom_take  = cpu_valid & cpu_rom & blank;
  assign vid_owned = (slot == SLOT_VID_A) | cfg_hires;

  always_comb begin
    cpu_gnt  = 1'b0;
    vid_gnt  = 1'b0;
    rfsh_gnt = 1'b0;
    unique case (slot)
      SLOT_CPU_A: cpu_gnt = cpu_valid;
      SLOT_CPU_B: cpu_gnt = cpu_valid & (cfg_turbo | cpu_rom);
      SLOT_VID_A, SLOT_VID_B: begin
        if (blank) begin
          cpu_gnt  = rom_take;
          rfsh_gnt = ~rom_take;
        end else begin
          vid_gnt  = vid_req & vid_owned;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/msa_wait_meter.sv
module msa_wait_meter #(
  parameter int unsigned WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_last,
  input  logic              cpu_valid,
  input  logic              cpu_gnt,
  output logic [WAIT_W-1:0] cpu_wait
);
  logic [WAIT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      cpu_wait <= '0;
    end else if (slot_last && cpu_gnt) begin
      cpu_wait <= run_q;
      run_q    <= '0;
    end else if (slot_last && cpu_valid) begin
      run_q    <= run_q + 1'b1;
    end else if (!cpu_valid) begin
      run_q    <= '0;
    end
  end
endmodule

// File: rtl/mem_slot_arbiter.sv
module mem_slot_arbiter
  import msa_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned WAIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hires,
  input  logic              cfg_turbo,
  input  logic              blank,
  input  logic              cpu_valid,
  input  logic              cpu_rom,
  output logic              cpu_ready,
  output logic [WAIT_W-1:0] cpu_wait,
  input  logic              vid_req,
  output logic              vid_gnt,
  output logic              rfsh_gnt,
  output logic [1:0]        slot_idx
);
  slot_e slot;
  logic  slot_last;
  logic  cpu_gnt;

  msa_slot_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (slot),
    .slot_last (slot_last)
  );

  msa_slot_decode u_decode (
    .slot      (slot),
    .cfg_hires (cfg_hires),
    .cfg_turbo (cfg_turbo),
    .blank     (blank),
    .cpu_valid (cpu_valid),
    .cpu_rom   (cpu_rom),
    .vid_req   (vid_req),
    .cpu_gnt   (cpu_gnt),
    .vid_gnt   (vid_gnt),
    .rfsh_gnt  (rfsh_gnt)
  );

  msa_wait_meter #(.WAIT_W(WAIT_W)) u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_last (slot_last),
    .cpu_valid (cpu_valid),
    .cpu_gnt   (cpu_gnt),
    .cpu_wait  (cpu_wait)
  );

  assign cpu_ready = cpu_gnt & slot_last;
  assign slot_idx  = slot;
endmodule

// File: rtl/msa_checker.sv
module msa_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_hires,
  input logic       cfg_turbo,
  input logic       blank,
  input logic       cpu_valid,
  input logic       cpu_rom,
  input logic       cpu_ready,
  input logic       vid_gnt,
  input logic       rfsh_gnt,
  input logic [1:0] slot_idx
);
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slot_idx) |-> (slot_idx == 2'($past(slot_idx) + 2'd1))); // R2

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid); // R3

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R3

  AST_SECOND_CPU_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && slot_idx == 2'd1) |-> (cfg_turbo || cpu_rom)); // R4

  AST_VIDEO_OWNS_DISPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && slot_idx[1]) |-> (blank && cpu_rom)); // R5

  AST_HIRES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_gnt && slot_idx == 2'd3) |-> cfg_hires); // R6

  AST_BLANK_NO_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !vid_gnt); // R7

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_ready, vid_gnt, rfsh_gnt})); // R9
endmodule

bind mem_slot_arbiter msa_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_hires (cfg_hires),
  .cfg_turbo (cfg_turbo),
  .blank     (blank),
  .cpu_valid (cpu_valid),
  .cpu_rom   (cpu_rom),
  .cpu_ready (cpu_ready),
  .vid_gnt   (vid_gnt),
  .rfsh_gnt  (rfsh_gnt),
  .slot_idx  (slot_idx)
);

// File: tb/sim_mem_slot_arbiter.sv
module sim_mem_slot_arbiter;
  localparam int CLK_DIV = 4;
  localparam int WAIT_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_hires = 1'b0, cfg_turbo = 1'b0, blank = 1'b0;
  logic cpu_valid = 1'b0, cpu_rom = 1'b0, vid_req = 1'b0;
  logic cpu_ready, vid_gnt, rfsh_gnt;
  logic [WAIT_W-1:0] cpu_wait;
  logic [1:0] slot_idx;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  mem_slot_arbiter #(.CLK_DIV(CLK_DIV), .WAIT_W(WAIT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_hires(cfg_hires), .cfg_turbo(cfg_turbo),
    .blank(blank), .cpu_valid(cpu_valid), .cpu_rom(cpu_rom),
    .cpu_ready(cpu_ready), .cpu_wait(cpu_wait), .vid_req(vid_req),
    .vid_gnt(vid_gnt), .rfsh_gnt(rfsh_gnt), .slot_idx(slot_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit cpu_ok(int s, bit turbo, bit bl, bit rom);
    if (s == 0) return 1'b1;
    if (s == 1) return turbo | rom;
    return bl & rom;
  endfunction

  function automatic bit vid_exp(int s, bit hires, bit bl, bit vr);
    return !bl && vr && (s == 2 || (s == 3 && hires));
  endfunction

  function automatic bit rf_exp(int s, bit bl, bit val, bit rom);
    return bl && s >= 2 && !(val && rom);
  endfunction

  task automatic align(input int s);
    int prev;
    prev = slot_idx;
    forever begin
      @(negedge clk);
      if (slot_idx == 2'(s) && prev != s) break;
      prev = slot_idx;
    end
  endtask

  task automatic wait_ack();
    for (int i = 0; i < 64; i++) begin
      #1;
      if (cpu_ready) break;
      @(negedge clk);
    end
  endtask

  task automatic b2b(input bit turbo, input int exp);
    cfg_turbo = turbo; cfg_hires = 0; blank = 0; cpu_rom = 0;
    align(0);
    cpu_valid = 1;
    wait_ack();
    @(negedge clk);
    wait_ack();
    @(negedge clk);
    cpu_valid = 0;
    #1;
    chk(cpu_wait == WAIT_W'(exp), "R10 back-to-back wait", cpu_wait, exp);
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    vid_req = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(slot_idx == 0, "R1 reset slot", slot_idx, 0);
    chk(!cpu_ready && !vid_gnt && !rfsh_gnt, "R1 reset grants",
        {cpu_ready, vid_gnt, rfsh_gnt}, 0);
    chk(cpu_wait == 0, "R1 reset wait", cpu_wait, 0);
    vid_req = 0;
    @(negedge clk);
    rst_n = 1;

    // R2: slot timing and order
    begin
      int cnt;
      int prev;
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (slot_idx == 0);
      chk(cnt == CLK_DIV, "R2 first slot length", cnt, CLK_DIV);
      for (int t = 0; t < 8; t++) begin
        prev = slot_idx;
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (slot_idx == 2'(prev));
        chk(cnt == CLK_DIV, "R2 slot length", cnt, CLK_DIV);
        chk(slot_idx == 2'(prev + 1), "R2 slot order", slot_idx, (prev + 1) % 4);
      end
    end

    // Sweep: every configuration, every start slot
    for (int cfg = 0; cfg < 32; cfg++) begin
      for (int s = 0; s < 4; s++) begin
        bit hi, tu, bl, rom, vr;
        int k, cyc, es;
        string rq;
        hi = cfg[0]; tu = cfg[1]; bl = cfg[2]; rom = cfg[3]; vr = cfg[4];
        cfg_hires = hi; cfg_turbo = tu; blank = bl; vid_req = vr; cpu_rom = rom;
        align(s);
        cpu_valid = 1;
        k = 0;
        while (!cpu_ok((s + k) % 4, tu, bl, rom)) k++;
        es = (s + k) % 4;
        cyc = 0;
        for (int i = 0; i < 64; i++) begin
          #1;
          rq = bl ? "R7" : (slot_idx == 3 ? "R6" : "R5");
          chk(vid_gnt == vid_exp(slot_idx, hi, bl, vr), {rq, " video grant"},
              vid_gnt, vid_exp(slot_idx, hi, bl, vr));
          chk(rfsh_gnt == rf_exp(slot_idx, bl, 1'b1, rom), "R7 refresh grant",
              rfsh_gnt, rf_exp(slot_idx, bl, 1'b1, rom));
          chk($countones({cpu_ready, vid_gnt, rfsh_gnt}) <= 1, "R9 single owner",
              $countones({cpu_ready, vid_gnt, rfsh_gnt}), 1);
          if (cpu_ready) break;
          @(negedge clk);
          cyc++;
        end
        rq = (es == 0) ? "R3" : (es == 1) ? "R4" : "R7";
        chk(cpu_ready && slot_idx == 2'(es), {rq, " serving slot"}, slot_idx, es);
        chk(cyc == 4 * k + CLK_DIV - 1, "R3 ack timing", cyc, 4 * k + CLK_DIV - 1);
        @(negedge clk);
        cpu_valid = 0;
        #1;
        chk(!cpu_ready, "R3 single-clock ack", cpu_ready, 0);
        chk(cpu_wait == WAIT_W'(k), "R8 wait count", cpu_wait, k);
        chk(rfsh_gnt == rf_exp(slot_idx, bl, 1'b0, rom), "R7 refresh after drop",
            rfsh_gnt, rf_exp(slot_idx, bl, 1'b0, rom));
      end
    end

    b2b(1'b1, 0);
    b2b(1'b0, 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule